// File: doc/BRIEF.md
# Multicast Hash Receive Address Filter

This block decides whether a received Ethernet frame should be kept, using only its 48-bit destination address. The six address bytes arrive one per clock on a byte stream. A start strobe marks the first byte and a valid strobe qualifies every byte. While the bytes stream in, the block does three things at once:

- it compares them against a programmed station address;
- it tests them for the broadcast and group (multicast) classes;
- it runs a bit-serial CRC-32 whose top six bits select one bit of a 64-bit multicast hash table.

A four-bit accept-enable word chooses which classes may pass. The result is a registered accept/reject pair with three class flags. It appears one cycle after the sixth address byte and is held until the next frame begins.

The hash table is loaded as two 32-bit words. A build-time parameter selects one of two word and byte orders, which lets the same block serve either host register layout. A frame that ends before its address is complete is rejected.

Top module: `mcast_addr_filter`

## Requirements
- R1: After reset, `dec_valid`, `accept`, `reject`, `flag_bcast`, `flag_phys` and `flag_mcast` are all 0, and the hash table holds all zeros.
- R2: The hash CRC is seeded with all ones at each frame start. It takes each address byte least significant bit first. For every bit, the feedback is CRC bit 31 XOR the data bit; the register shifts left by one and is XORed with 0x04C11DB7 when the feedback is 1. The table index is bits 31:26 of the CRC after the sixth byte.
- R3: With `BYTE_SWAP`=0, a write with `tbl_wr_sel`=0 loads table bits 31:0 and a write with `tbl_wr_sel`=1 loads table bits 63:32. Data bit n lands in table bit n of that half.
- R4: With `BYTE_SWAP`=1, a write with `tbl_wr_sel`=0 loads table bits 63:32 with the byte-reversed word, {d[7:0],d[15:8],d[23:16],d[31:24]}. A write with `tbl_wr_sel`=1 loads table bits 31:0 with the same reversal.
- R5: `cfg_accept` bit 0 accepts every complete frame, bit 1 accepts a station-address match, bit 2 accepts a multicast frame whose hash table bit is 1, and bit 3 accepts broadcast. A frame matching no enabled class is rejected.
- R6: The station address is byte 0 in `sta_lo[7:0]`, byte 1 in `sta_lo[15:8]`, byte 2 in `sta_lo[23:16]`, byte 3 in `sta_lo[31:24]`, byte 4 in `sta_hi[7:0]` and byte 5 in `sta_hi[15:8]`. Byte 0 is the first byte on the stream.
- R7: An address with all 48 bits set is broadcast. An address whose first byte has bit 0 set and which is not broadcast is multicast. Broadcast is never reported as multicast, nor accepted through the multicast enable.
- R8: The cycle after the sixth address byte is sampled, `dec_valid` is 1 and the result is present. The result holds, and further bytes without a start strobe are ignored, until a new start byte. The cycle after that start byte, `dec_valid` is 0.
- R9: If `frm_end` arrives before the sixth address byte, then on the following cycle `dec_valid`=1, `reject`=1, `accept`=0, and no class flag is set.
- R10: The class flags describe the frame only when it is accepted; on reject all three are 0. While `dec_valid` is 1, exactly one of `accept` and `reject` is 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| frm_start | input | 1 | Marks the first address byte (qualified by byte_vld) |
| byte_vld | input | 1 | Address byte valid |
| byte_data | input | 8 | Address byte |
| frm_end | input | 1 | Frame ended |
| cfg_accept | input | 4 | Class accept enables |
| sta_lo | input | 32 | Station address bytes 0..3 |
| sta_hi | input | 16 | Station address bytes 4..5 |
| tbl_wr_en | input | 1 | Hash table word write strobe |
| tbl_wr_sel | input | 1 | Which table word is written |
| tbl_wr_data | input | 32 | Hash table write data |
| dec_valid | output | 1 | Decision present |
| accept | output | 1 | Frame accepted |
| reject | output | 1 | Frame rejected |
| flag_bcast | output | 1 | Accepted frame is broadcast |
| flag_phys | output | 1 | Accepted frame matched the station address |
| flag_mcast | output | 1 | Accepted frame is multicast |

## Verification
The bench computes the hash index of each group address itself. It then fills the table either with only that bit set or with every bit except that one. A CRC with the wrong bit order, seed or feedback would therefore accept where a reject is expected, or the reverse.

Two instances run side by side, one in each table layout. A mix-up of halves or byte order in either layout misses the single marked bit.

The station match is probed with an address that differs only in its last byte, which catches a misplaced high station byte. A broadcast with only the multicast enable and an all-ones table catches a classifier that lets broadcast count as multicast. The remaining checks cover a truncated frame, which must be rejected with no flags, and extra bytes after the decision, which must leave the held result unchanged.

// File: rtl/mcf_pkg.sv
package mcf_pkg;

   // one address byte through the serial CRC, LSB first
   function automatic logic [31:0] crc_step_byte(input logic [31:0] crc_in,
                                                 input logic [7:0]  data,
                                                 input logic [31:0] poly);
      logic [31:0] c;
      logic        fb;
      c = crc_in;
      for (int j = 0; j < 8; j++) begin
         fb = c[31] ^ data[j];
         c  = {c[30:0], 1'b0};
         if (fb) c = c ^ poly;
      end
      return c;
   endfunction

   function automatic logic [31:0] byte_rev32(input logic [31:0] w);
      return {w[7:0], w[15:8], w[23:16], w[31:24]};
   endfunction

endpackage

// File: rtl/mcf_crc_unit.sv
module mcf_crc_unit #(
   parameter int          HASH_BITS = 6,
   parameter logic [31:0] POLY      = 32'h04C11DB7
) (
   input  logic                 clk,
   input  logic                 rst_n,
   input  logic                 take,
   input  logic                 seed,
   input  logic [7:0]           data,
   output logic [HASH_BITS-1:0] hash_idx
);
   import mcf_pkg::*;

   logic [31:0] crc_q;
   logic [31:0] crc_src;
   logic [31:0] crc_n;

   assign crc_src  = seed ? '1 : crc_q;
   assign crc_n    = crc_step_byte(crc_src, data, POLY);
   assign hash_idx = crc_n[31 -: HASH_BITS];

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)    crc_q <= '1;
      else if (take) crc_q <= crc_n;
   end
endmodule

// File: rtl/mcf_hash_table.sv
module mcf_hash_table #(
   parameter int HASH_BITS = 6,
   parameter bit BYTE_SWAP = 1'b0
) (
   input  logic                 clk,
   input  logic                 rst_n,
   input  logic                 wr_en,
   input  logic                 wr_sel,
   input  logic [31:0]          wr_data,
   input  logic [HASH_BITS-1:0] idx,
   output logic                 hit
);
   import mcf_pkg::*;

   localparam int TBL_W  = 1 << HASH_BITS;
   localparam int HALF_W = TBL_W / 2;

   logic [TBL_W-1:0] tbl_q;

   generate
      if (BYTE_SWAP) begin : g_swapped
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) tbl_q <= '0;
            else if (wr_en) begin
               if (!wr_sel) tbl_q[TBL_W-1:HALF_W] <= byte_rev32(wr_data);
               else         tbl_q[HALF_W-1:0]     <= byte_rev32(wr_data);
            end
         end
      end else begin : g_linear
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) tbl_q <= '0;
            else if (wr_en) begin
               if (!wr_sel) tbl_q[HALF_W-1:0]     <= wr_data;
               else         tbl_q[TBL_W-1:HALF_W] <= wr_data;
            end
         end
      end
   endgenerate

   assign hit = tbl_q[idx];
endmodule

// File: rtl/mcf_classifier.sv
module mcf_classifier (
   input  logic       clk,
   input  logic       rst_n,
   input  logic       take,
   input  logic       seed,
   input  logic [7:0] data,
   input  logic [7:0] sta_byte,
   output logic       phys_n,
   output logic       bcast_n,
   output logic       group_n
);
   logic phys_q, bcast_q, group_q;

   assign phys_n  = (seed | phys_q)  & (data == sta_byte);
   assign bcast_n = (seed | bcast_q) & (&data);
   assign group_n = seed ? data[0] : group_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         phys_q  <= 1'b0;
         bcast_q <= 1'b0;
         group_q <= 1'b0;
      end else if (take) begin
         phys_q  <= phys_n;
         bcast_q <= bcast_n;
         group_q <= group_n;
      end
   end
endmodule

// File: rtl/mcast_addr_filter.sv
module mcast_addr_filter #(
   parameter int          ADDR_BYTES = 6,
   parameter int          HASH_BITS  = 6,
   parameter bit          BYTE_SWAP  = 1'b0,
   parameter logic [31:0] CRC_POLY   = 32'h04C11DB7
) (
   input  logic        clk,
   input  logic        rst_n,
   input  logic        frm_start,
   input  logic        byte_vld,
   input  logic [7:0]  byte_data,
   input  logic        frm_end,
   input  logic [3:0]  cfg_accept,
   input  logic [31:0] sta_lo,
   input  logic [15:0] sta_hi,
   input  logic        tbl_wr_en,
   input  logic        tbl_wr_sel,
   input  logic [31:0] tbl_wr_data,
   output logic        dec_valid,
   output logic        accept,
   output logic        reject,
   output logic        flag_bcast,
   output logic        flag_phys,
   output logic        flag_mcast
);
   localparam int CNT_W = $clog2(ADDR_BYTES + 1);
   localparam logic [CNT_W-1:0] LAST_IDX = CNT_W'(ADDR_BYTES - 1);

   generate
      if (ADDR_BYTES != 6) begin : g_bad_len
         $error("mcast_addr_filter: ADDR_BYTES must be 6");
      end
      if (HASH_BITS != 6) begin : g_bad_hash
         $error("mcast_addr_filter: HASH_BITS must be 6 for two 32-bit table words");
      end
   endgenerate

   // station bytes in wire order
   logic [7:0] sta_b [ADDR_BYTES];
   logic [47:0] sta_flat;
   assign sta_flat = {sta_hi, sta_lo};
   generate
      for (genvar k = 0; k < ADDR_BYTES; k++) begin : g_sta
         assign sta_b[k] = sta_flat[8*k +: 8];
      end
   endgenerate

   logic             active_q;
   logic [CNT_W-1:0] cnt_q;
   logic             first, take, last, short_end;
   logic [CNT_W-1:0] idx;
   logic [7:0]       sta_sel;

   assign first     = byte_vld & frm_start;
   assign take      = byte_vld & (frm_start | active_q);
   assign idx       = frm_start ? '0 : cnt_q;
   assign last      = take & (idx == LAST_IDX);
   assign short_end = frm_end & ~last & (active_q | take);

   always_comb begin
      sta_sel = '0;
      for (int k = 0; k < ADDR_BYTES; k++)
         if (idx == CNT_W'(k)) sta_sel = sta_b[k];
   end

   logic [HASH_BITS-1:0] hash_idx;
   logic                 hash_hit;
   logic                 phys_n, bcast_n, group_n;

   mcf_crc_unit #(.HASH_BITS(HASH_BITS), .POLY(CRC_POLY)) u_crc (
      .clk(clk), .rst_n(rst_n), .take(take), .seed(frm_start),
      .data(byte_data), .hash_idx(hash_idx));

   mcf_hash_table #(.HASH_BITS(HASH_BITS), .BYTE_SWAP(BYTE_SWAP)) u_tbl (
      .clk(clk), .rst_n(rst_n), .wr_en(tbl_wr_en), .wr_sel(tbl_wr_sel),
      .wr_data(tbl_wr_data), .idx(hash_idx), .hit(hash_hit));

   mcf_classifier u_cls (
      .clk(clk), .rst_n(rst_n), .take(take), .seed(frm_start),
      .data(byte_data), .sta_byte(sta_sel),
      .phys_n(phys_n), .bcast_n(bcast_n), .group_n(group_n));

   logic is_bcast, is_mcast, acc_c;
   assign is_bcast = bcast_n;
   assign is_mcast = group_n & ~bcast_n;
   assign acc_c    = cfg_accept[0]
                   | (cfg_accept[1] & phys_n)
                   | (cfg_accept[2] & is_mcast & hash_hit)
                   | (cfg_accept[3] & is_bcast);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         active_q   <= 1'b0;
         cnt_q      <= '0;
         dec_valid  <= 1'b0;
         accept     <= 1'b0;
         reject     <= 1'b0;
         flag_bcast <= 1'b0;
         flag_phys  <= 1'b0;
         flag_mcast <= 1'b0;
      end else begin
         if (take) cnt_q <= idx + 1'b1;

         if (last || short_end) active_q <= 1'b0;
         else if (first)        active_q <= 1'b1;

         if (last) begin
            dec_valid  <= 1'b1;
            accept     <= acc_c;
            reject     <= ~acc_c;
            flag_bcast <= acc_c & is_bcast;
            flag_phys  <= acc_c & phys_n;
            flag_mcast <= acc_c & is_mcast;
         end else if (short_end) begin
            dec_valid  <= 1'b1;
            accept     <= 1'b0;
            reject     <= 1'b1;
            flag_bcast <= 1'b0;
            flag_phys  <= 1'b0;
            flag_mcast <= 1'b0;
         end else if (first) begin
            dec_valid  <= 1'b0;
            accept     <= 1'b0;
            reject     <= 1'b0;
            flag_bcast <= 1'b0;
            flag_phys  <= 1'b0;
            flag_mcast <= 1'b0;
         end
      end
   end
endmodule

// File: rtl/mcf_filter_chk.sv
module mcf_filter_chk (
   input logic clk,
   input logic rst_n,
   input logic frm_start,
   input logic byte_vld,
   input logic frm_end,
   input logic dec_valid,
   input logic accept,
   input logic reject,
   input logic flag_bcast,
   input logic flag_phys,
   input logic flag_mcast
);
   // R10
   one_verdict_chk: assert property (@(posedge clk) disable iff (!rst_n)
      dec_valid |-> (accept != reject));

   // R10
   flags_need_accept_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (flag_bcast || flag_phys || flag_mcast) |-> (dec_valid && accept));

   // R7
   bcast_not_mcast_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !(flag_bcast && flag_mcast));

   // R8
   verdict_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (dec_valid && !(frm_start && byte_vld)) |=>
         (dec_valid && $stable(accept) && $stable(flag_bcast)
          && $stable(flag_phys) && $stable(flag_mcast)));

   // R8
   verdict_cause_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(dec_valid) |-> $past(byte_vld || frm_end));
endmodule

bind mcast_addr_filter mcf_filter_chk u_filter_chk (
   .clk(clk), .rst_n(rst_n), .frm_start(frm_start), .byte_vld(byte_vld),
   .frm_end(frm_end), .dec_valid(dec_valid), .accept(accept), .reject(reject),
   .flag_bcast(flag_bcast), .flag_phys(flag_phys), .flag_mcast(flag_mcast));

// File: tb/mcast_addr_filter_tb.sv
module mcast_addr_filter_tb;
   localparam int CLK_PERIOD = 10;
   localparam logic [31:0] POLY = 32'h04C11DB7;

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic frm_start = 0, byte_vld = 0, frm_end = 0;
   logic [7:0] byte_data = '0;
   logic [3:0] cfg_accept = '0;
   logic [31:0] sta_lo = '0;
   logic [15:0] sta_hi = '0;
   logic wa_en = 0, wa_sel = 0, wb_en = 0, wb_sel = 0;
   logic [31:0] wa_d = '0, wb_d = '0;

   logic dv_a, acc_a, rej_a, fb_a, fp_a, fm_a;
   logic dv_b, acc_b, rej_b, fb_b, fp_b, fm_b;

   int checks = 0;
   int errors = 0;

   always #(CLK_PERIOD/2) clk = ~clk;

   mcast_addr_filter #(.BYTE_SWAP(1'b0)) u_dut (
      .clk(clk), .rst_n(rst_n), .frm_start(frm_start), .byte_vld(byte_vld),
      .byte_data(byte_data), .frm_end(frm_end), .cfg_accept(cfg_accept),
      .sta_lo(sta_lo), .sta_hi(sta_hi), .tbl_wr_en(wa_en), .tbl_wr_sel(wa_sel),
      .tbl_wr_data(wa_d), .dec_valid(dv_a), .accept(acc_a), .reject(rej_a),
      .flag_bcast(fb_a), .flag_phys(fp_a), .flag_mcast(fm_a));

   mcast_addr_filter #(.BYTE_SWAP(1'b1)) u_dut_sw (
      .clk(clk), .rst_n(rst_n), .frm_start(frm_start), .byte_vld(byte_vld),
      .byte_data(byte_data), .frm_end(frm_end), .cfg_accept(cfg_accept),
      .sta_lo(sta_lo), .sta_hi(sta_hi), .tbl_wr_en(wb_en), .tbl_wr_sel(wb_sel),
      .tbl_wr_data(wb_d), .dec_valid(dv_b), .accept(acc_b), .reject(rej_b),
      .flag_bcast(fb_b), .flag_phys(fp_b), .flag_mcast(fm_b));

   function automatic logic [5:0] ref_idx(input logic [47:0] a);
      logic [31:0] c;
      logic fb;
      c = '1;
      for (int k = 0; k < 6; k++)
         for (int j = 0; j < 8; j++) begin
            fb = c[31] ^ a[8*k + j];
            c  = {c[30:0], 1'b0};
            if (fb) c = c ^ POLY;
         end
      return c[31:26];
   endfunction

   function automatic logic [31:0] rev(input logic [31:0] w);
      return {w[7:0], w[15:8], w[23:16], w[31:24]};
   endfunction

   task automatic check(input string req, input string what,
                        input logic [31:0] act, input logic [31:0] exp);
      checks++;
      if (act !== exp) begin
         errors++;
         $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
      end
   endtask

   // verdict of both instances: {dv,acc,rej,bcast,phys,mcast}
   task automatic check_dec(input string req, input logic exp_acc,
                            input logic eb, input logic ep, input logic em,
                            input bit both);
      logic [5:0] exp;
      exp = {1'b1, exp_acc, ~exp_acc, eb & exp_acc, ep & exp_acc, em & exp_acc};
      check(req, "plain layout verdict", {26'd0, dv_a, acc_a, rej_a, fb_a, fp_a, fm_a}, {26'd0, exp});
      if (both)
         check(req, "swapped layout verdict", {26'd0, dv_b, acc_b, rej_b, fb_b, fp_b, fm_b}, {26'd0, exp});
   endtask

   task automatic send(input logic [47:0] a, input int n);
      for (int k = 0; k < n; k++) begin
         frm_start = (k == 0);
         byte_vld  = 1'b1;
         byte_data = a[8*k +: 8];
         @(negedge clk);
      end
      frm_start = 0; byte_vld = 0; byte_data = '0;
   endtask

   task automatic end_pulse();
      frm_end = 1'b1;
      @(negedge clk);
      frm_end = 1'b0;
   endtask

   // load a 64-bit table image into both instances, each in its own layout
   task automatic load_table(input logic [63:0] t);
      wa_en = 1; wa_sel = 0; wa_d = t[31:0];
      wb_en = 1; wb_sel = 0; wb_d = rev(t[63:32]);
      @(negedge clk);
      wa_sel = 1; wa_d = t[63:32];
      wb_sel = 1; wb_d = rev(t[31:0]);
      @(negedge clk);
      wa_en = 0; wb_en = 0;
   endtask

   task automatic t_reset();
      check("R1", "reset outputs plain", {26'd0, dv_a, acc_a, rej_a, fb_a, fp_a, fm_a}, 32'd0);
      check("R1", "reset outputs swapped", {26'd0, dv_b, acc_b, rej_b, fb_b, fp_b, fm_b}, 32'd0);
      // empty table: a group frame with only the hash class enabled is rejected
      cfg_accept = 4'b0100;
      send(48'h00_00_00_5E_00_01, 6);
      check_dec("R1", 1'b0, 0, 0, 0, 1);
      end_pulse();
   endtask

   task automatic t_bcast();
      cfg_accept = 4'b1000;
      send(48'hFFFF_FFFF_FFFF, 6);
      check_dec("R5", 1'b1, 1, 0, 0, 1);
      end_pulse();
      cfg_accept = 4'b0000;
      send(48'hFFFF_FFFF_FFFF, 6);
      check_dec("R5", 1'b0, 0, 0, 0, 1);
      end_pulse();
   endtask

   task automatic t_bcast_not_mcast();
      load_table('1);
      cfg_accept = 4'b0100;
      send(48'hFFFF_FFFF_FFFF, 6);
      check_dec("R7", 1'b0, 0, 0, 0, 1);
      end_pulse();
      load_table('0);
   endtask

   task automatic t_phys();
      logic [47:0] a;
      a = 48'h55_44_33_22_11_02;
      sta_lo = a[31:0]; sta_hi = a[47:32];
      cfg_accept = 4'b0010;
      send(a, 6);
      check_dec("R6", 1'b1, 0, 1, 0, 1);
      end_pulse();
      send(a ^ 48'h01_00_00_00_00_00, 6);
      check_dec("R6", 1'b0, 0, 0, 0, 1);
      end_pulse();
   endtask

   task automatic t_hash(input logic [47:0] a);
      logic [5:0] ix;
      logic [63:0] t;
      ix = ref_idx(a);
      cfg_accept = 4'b0100;
      t = 64'd1 << ix;
      load_table(t);
      send(a, 6);
      // R2 R3 R4: hit on exactly the computed bit
      check_dec("R2", 1'b1, 0, 0, 1, 1);
      end_pulse();
      load_table(~t);
      send(a, 6);
      check_dec("R4", 1'b0, 0, 0, 0, 1);
      end_pulse();
      load_table('0);
   endtask

   task automatic t_half_probe();
      // one bit per half in the plain layout only: R3
      logic [47:0] a;
      logic [5:0] ix;
      a = 48'h00_00_00_5E_00_01;
      ix = ref_idx(a);
      cfg_accept = 4'b0100;
      wa_en = 1; wa_sel = ix[5]; wa_d = 32'd1 << ix[4:0];
      @(negedge clk);
      wa_en = 0;
      send(a, 6);
      check("R3", "half select accept", {31'd0, acc_a}, 32'd1);
      end_pulse();
      wa_en = 1; wa_sel = ix[5]; wa_d = '0;
      @(negedge clk);
      wa_en = 0;
   endtask

   task automatic t_accept_all();
      cfg_accept = 4'b0001;
      sta_lo = 32'h0; sta_hi = 16'h0;
      send(48'hAB_CD_EF_01_23_46, 6);
      check_dec("R5", 1'b1, 0, 0, 0, 1);
      end_pulse();
   endtask

   task automatic t_short();
      cfg_accept = 4'b1111;
      send(48'hFFFF_FFFF_FFFF, 3);
      end_pulse();
      check_dec("R9", 1'b0, 0, 0, 0, 1);
   endtask

   task automatic t_timing_hold();
      logic [47:0] a;
      a = 48'h66_77_88_99_AA_10;
      sta_lo = a[31:0]; sta_hi = a[47:32];
      cfg_accept = 4'b0010;
      send(a, 5);
      check("R8", "no verdict before byte six", {31'd0, dv_a}, 32'd0);
      frm_start = 0; byte_vld = 1; byte_data = a[47:40];
      @(negedge clk);
      byte_vld = 0;
      check_dec("R8", 1'b1, 0, 1, 0, 1);
      // stray bytes without a start strobe
      byte_vld = 1; byte_data = 8'hFF;
      repeat (3) @(negedge clk);
      byte_vld = 0;
      check_dec("R8", 1'b1, 0, 1, 0, 1);
      end_pulse();
      check_dec("R10", 1'b1, 0, 1, 0, 1);
      send(a, 1);
      check("R8", "cleared by new start", {31'd0, dv_a}, 32'd0);
      end_pulse();
      check_dec("R9", 1'b0, 0, 0, 0, 1);
   endtask

   task automatic t_reject_flags();
      // group frame, hash bit clear, multicast enable only: no flags on reject
      cfg_accept = 4'b0100;
      send(48'h00_00_00_00_00_33, 6);
      check_dec("R10", 1'b0, 0, 0, 0, 1);
      end_pulse();
      // group frame accepted through accept-all carries the multicast flag
      cfg_accept = 4'b0001;
      send(48'h00_00_00_00_00_33, 6);
      check_dec("R7", 1'b1, 0, 0, 1, 1);
      end_pulse();
   endtask

   initial begin : watchdog
      repeat (100000) @(posedge clk);
      errors++;
      checks++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end

   initial begin
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      t_reset();
      t_bcast();
      t_bcast_not_mcast();
      t_phys();
      t_hash(48'hFB_00_00_5E_00_01);
      t_hash(48'h00_00_00_00_00_33);
      t_hash(48'h12_34_56_78_9A_0F);
      t_half_probe();
      t_accept_all();
      t_short();
      t_timing_hold();
      t_reject_flags();
      repeat (2) @(negedge clk);
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end
endmodule